// File: doc/BRIEF.md
# Segment Presence Fault Classifier

This block sits next to the descriptor-load path of a protected-mode processor core. It checks the present bit of each fetched descriptor. Descriptors are fetched when the core loads a segment register, the local descriptor table register or the task register, or when it uses a gate or a task-state segment. On each one-cycle request strobe the block decides whether a fault must be raised and which vector it carries. It also builds the error code and picks the saved return address.

The vector depends on two things. The first is the access kind: a missing stack segment becomes a stack fault, and a missing LDT during a task switch becomes an invalid-TSS fault. The second is the event already being delivered: a contributory exception or a page fault in flight turns any miss into a double fault. The error code takes its external-event and interrupt-table flags from the request context. When a descriptor is present, the block grants the register load enable instead of raising a fault.

All outputs are registered and appear one clock after the request. Fetching the descriptor, pushing the error code and dispatching to the handler are done elsewhere.

Top module: `seg_presence_classifier`

## Requirements
- R1: A synchronous active-high reset clears `fault_valid`, `fault_vec`, `fault_err`, `fault_ip` and `load_en` to zero at the next clock edge.
- R2: `fault_valid` pulses one clock after a cycle with `req_valid` high and `desc_present` low, for access kinds 0 to 5. It never pulses after a cycle with `desc_present` high or with `req_valid` low.
- R3: Access kind encodings are: 0 = code/data segment load, 1 = stack segment load, 2 = LDT register load, 3 = task register load, 4 = gate use, 5 = TSS use. A miss on kinds 0, 3, 4 or 5, or on kind 2 outside a task switch, gives vector 11.
- R4: A miss on kind 1 gives vector 12 (stack fault).
- R5: A miss on kind 2 while `in_task_switch` is high gives vector 10 (invalid TSS).
- R6: When `ev_contrib` is high, any miss gives vector 8 (double fault) with an all-zero error code. This overrides R3, R4 and R5.
- R7: For a non-double-fault miss, the error code is built as follows: bit 0 = `ev_ext`, bit 1 = interrupt-table flag, bit 2 = `sel[2]`, bits 15:3 = `sel[15:3]`.
- R8: The interrupt-table flag (bit 1) is set only for kind 4 with `via_idt` high. In that case bit 2 is zero and bits 15:3 hold `int_vec` zero-extended.
- R9: The saved address `fault_ip` is chosen in this order:
  - For kind 4 it is `ip_invoker`.
  - Otherwise, for kinds 0, 1 or 2 during a task switch, it is `ip_newtask`.
  - Otherwise it is `ip_fault`.
- R10: `load_en` pulses one clock after a request with `desc_present` high and kind 0 to 3. It is never high together with `fault_valid`, and is never raised for kinds 4 to 7.
- R11: Kinds 6 and 7 are reserved and produce neither a fault nor a load enable.
- R12: Whenever `fault_valid` is low, `fault_vec`, `fault_err` and `fault_ip` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 3 | Access kind code (see R3) |
| desc_present | input | 1 | Present flag of the fetched descriptor |
| sel | input | 16 | Selector of the descriptor |
| int_vec | input | 8 | Interrupt vector being serviced (interrupt-table case) |
| in_task_switch | input | 1 | Request occurs inside a task switch |
| via_idt | input | 1 | Gate was reached through the interrupt table |
| ev_ext | input | 1 | Delivering an external interrupt or benign exception |
| ev_contrib | input | 1 | Delivering a contributory exception or page fault |
| ip_fault | input | 32 | Address of the faulting instruction |
| ip_invoker | input | 32 | Address of the instruction that invoked the gate |
| ip_newtask | input | 32 | First instruction of the new task |
| fault_valid | output | 1 | Registered fault strobe |
| fault_vec | output | 8 | Fault vector |
| fault_err | output | 16 | Error code |
| fault_ip | output | 32 | Saved return address |
| load_en | output | 1 | Target register write enable |

## Verification
The checker takes for granted that every input is a known value at each clock edge, and that the request fields are meaningful only in a cycle with `req_valid` high. It also treats `ev_contrib` as overriding everything else, so its vector and error-code properties hold whatever `via_idt` or `ev_ext` carry. The bench drives all inputs on the falling edge, holds them at defined values between requests and pulses `req_valid` for exactly one cycle. This keeps every sampled value inside those assumptions, including the back-to-back and reserved-kind cases.

// File: rtl/spfc_pkg.sv
package spfc_pkg;

  typedef enum logic [2:0] {
    AK_SEG    = 3'd0,
    AK_STACK  = 3'd1,
    AK_LDT    = 3'd2,
    AK_TR     = 3'd3,
    AK_GATE   = 3'd4,
    AK_TSS    = 3'd5,
    AK_RSV6   = 3'd6,
    AK_RSV7   = 3'd7
  } acc_kind_e;

  typedef enum logic [1:0] {
    RET_FAULT   = 2'd0,
    RET_INVOKER = 2'd1,
    RET_NEWTASK = 2'd2
  } ret_src_e;

  localparam int NUM_RET_SRC = 3;

  localparam logic [7:0] VEC_DF = 8'd8;
  localparam logic [7:0] VEC_TS = 8'd10;
  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_SS = 8'd12;

  function automatic logic kind_has_desc(input acc_kind_e k);
    return (k != AK_RSV6) && (k != AK_RSV7);
  endfunction

  function automatic logic kind_loads_reg(input acc_kind_e k);
    return (k == AK_SEG) || (k == AK_STACK) || (k == AK_LDT) || (k == AK_TR);
  endfunction

endpackage

// File: rtl/spfc_vector_sel.sv
module spfc_vector_sel
  import spfc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  acc_kind_e        kind,
  input  logic             present,
  input  logic             in_ts,
  input  logic             contrib,
  output logic             raise_o,
  output logic             is_df_o,
  output logic             ld_cap_o,
  output logic [VEC_W-1:0] vec_o
);

  always_comb begin
    raise_o  = !present && kind_has_desc(kind);
    ld_cap_o = kind_loads_reg(kind);
    is_df_o  = raise_o && contrib;
    vec_o    = '0;
    if (raise_o) begin
      if (contrib) begin
        vec_o = VEC_W'(VEC_DF);
      end else begin
        unique case (kind)
          AK_STACK: vec_o = VEC_W'(VEC_SS);
          AK_LDT:   vec_o = in_ts ? VEC_W'(VEC_TS) : VEC_W'(VEC_NP);
          default:  vec_o = VEC_W'(VEC_NP);
        endcase
      end
    end
  end

endmodule

// File: rtl/spfc_errcode_gen.sv
module spfc_errcode_gen #(
  parameter int SEL_W = 16,
  parameter int VEC_W = 8,
  parameter int ERR_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             idt_gate,
  input  logic             ext,
  input  logic             force_zero,
  output logic [ERR_W-1:0] err_o
);

  localparam int IDX_W = ERR_W - 3;
  localparam int PAD_W = IDX_W - VEC_W;

  logic [IDX_W-1:0] index_field;
  logic             ti_field;

  always_comb begin
    if (idt_gate) begin
      index_field = {{PAD_W{1'b0}}, int_vec};
      ti_field    = 1'b0;
    end else begin
      index_field = IDX_W'(sel[SEL_W-1:3]);
      ti_field    = sel[2];
    end
    if (force_zero) err_o = '0;
    else            err_o = {index_field, ti_field, idt_gate, ext};
  end

endmodule

// File: rtl/spfc_ret_sel.sv
module spfc_ret_sel
  import spfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  acc_kind_e         kind,
  input  logic              in_ts,
  input  logic [ADDR_W-1:0] ip_fault,
  input  logic [ADDR_W-1:0] ip_invoker,
  input  logic [ADDR_W-1:0] ip_newtask,
  output logic [ADDR_W-1:0] ip_o
);

  logic [ADDR_W-1:0] cand [NUM_RET_SRC];
  ret_src_e          src;

  assign cand[RET_FAULT]   = ip_fault;
  assign cand[RET_INVOKER] = ip_invoker;
  assign cand[RET_NEWTASK] = ip_newtask;

  always_comb begin
    if (kind == AK_GATE)
      src = RET_INVOKER;
    else if (in_ts && (kind == AK_SEG || kind == AK_STACK || kind == AK_LDT))
      src = RET_NEWTASK;
    else
      src = RET_FAULT;
  end

  assign ip_o = cand[src];

endmodule

// File: rtl/seg_presence_classifier.sv
module seg_presence_classifier
  import spfc_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              desc_present,
  input  logic [SEL_W-1:0]  sel,
  input  logic [VEC_W-1:0]  int_vec,
  input  logic              in_task_switch,
  input  logic              via_idt,
  input  logic              ev_ext,
  input  logic              ev_contrib,
  input  logic [ADDR_W-1:0] ip_fault,
  input  logic [ADDR_W-1:0] ip_invoker,
  input  logic [ADDR_W-1:0] ip_newtask,
  output logic              fault_valid,
  output logic [VEC_W-1:0]  fault_vec,
  output logic [ERR_W-1:0]  fault_err,
  output logic [ADDR_W-1:0] fault_ip,
  output logic              load_en
);

  acc_kind_e         kind;
  logic              raise_c;
  logic              is_df_c;
  logic              ld_cap_c;
  logic              idt_gate_c;
  logic              take_fault;
  logic [VEC_W-1:0]  vec_c;
  logic [ERR_W-1:0]  err_c;
  logic [ADDR_W-1:0] ip_c;

  assign kind       = acc_kind_e'(req_kind);
  assign idt_gate_c = via_idt && (kind == AK_GATE);
  assign take_fault = req_valid && raise_c;

  spfc_vector_sel #(.VEC_W(VEC_W)) u_vsel (
    .kind     (kind),
    .present  (desc_present),
    .in_ts    (in_task_switch),
    .contrib  (ev_contrib),
    .raise_o  (raise_c),
    .is_df_o  (is_df_c),
    .ld_cap_o (ld_cap_c),
    .vec_o    (vec_c)
  );

  spfc_errcode_gen #(.SEL_W(SEL_W), .VEC_W(VEC_W), .ERR_W(ERR_W)) u_err (
    .sel        (sel),
    .int_vec    (int_vec),
    .idt_gate   (idt_gate_c),
    .ext        (ev_ext),
    .force_zero (is_df_c),
    .err_o      (err_c)
  );

  spfc_ret_sel #(.ADDR_W(ADDR_W)) u_ret (
    .kind       (kind),
    .in_ts      (in_task_switch),
    .ip_fault   (ip_fault),
    .ip_invoker (ip_invoker),
    .ip_newtask (ip_newtask),
    .ip_o       (ip_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_vec   <= '0;
      fault_err   <= '0;
      fault_ip    <= '0;
      load_en     <= 1'b0;
    end else begin
      fault_valid <= take_fault;
      fault_vec   <= take_fault ? vec_c : '0;
      fault_err   <= take_fault ? err_c : '0;
      fault_ip    <= take_fault ? ip_c  : '0;
      load_en     <= req_valid && desc_present && ld_cap_c;
    end
  end

endmodule

// File: rtl/spfc_checker.sv
module spfc_checker #(
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic              desc_present,
  input logic              via_idt,
  input logic              ev_contrib,
  input logic              fault_valid,
  input logic [VEC_W-1:0]  fault_vec,
  input logic [ERR_W-1:0]  fault_err,
  input logic [ADDR_W-1:0] fault_ip,
  input logic              load_en
);

  assert_strobe_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> ($past(req_valid) && !$past(desc_present)));

  assert_present_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && desc_present) |=> !fault_valid);

  assert_vec_legal_R3: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_vec == VEC_W'(8) || fault_vec == VEC_W'(10) ||
                     fault_vec == VEC_W'(11) || fault_vec == VEC_W'(12)));

  assert_stack_vec_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !desc_present && req_kind == 3'd1 && !ev_contrib)
      |=> (fault_valid && fault_vec == VEC_W'(12)));

  assert_df_zero_code_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_vec == VEC_W'(8)) |-> (fault_err == '0));

  assert_idt_only_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_err[1]) |-> ($past(req_kind) == 3'd4 && $past(via_idt)));

  assert_no_load_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
    !(fault_valid && load_en));

  assert_reserved_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[2:1] == 2'b11) |=> (!fault_valid && !load_en));

  assert_quiet_payload_R12: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> (fault_vec == '0 && fault_err == '0 && fault_ip == '0));

endmodule

bind seg_presence_classifier spfc_checker #(
  .SEL_W(SEL_W), .VEC_W(VEC_W), .ERR_W(ERR_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_kind     (req_kind),
  .desc_present (desc_present),
  .via_idt      (via_idt),
  .ev_contrib   (ev_contrib),
  .fault_valid  (fault_valid),
  .fault_vec    (fault_vec),
  .fault_err    (fault_err),
  .fault_ip     (fault_ip),
  .load_en      (load_en)
);

// File: tb/sim_seg_presence_classifier.sv
`timescale 1ns/1ps
module sim_seg_presence_classifier;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic        desc_present = 1'b1;
  logic [15:0] sel = '0;
  logic [7:0]  int_vec = '0;
  logic        in_task_switch = 1'b0;
  logic        via_idt = 1'b0;
  logic        ev_ext = 1'b0;
  logic        ev_contrib = 1'b0;
  logic [31:0] ip_fault = '0;
  logic [31:0] ip_invoker = '0;
  logic [31:0] ip_newtask = '0;
  logic        fault_valid;
  logic [7:0]  fault_vec;
  logic [15:0] fault_err;
  logic [31:0] fault_ip;
  logic        load_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_presence_classifier u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .desc_present(desc_present), .sel(sel), .int_vec(int_vec),
    .in_task_switch(in_task_switch), .via_idt(via_idt), .ev_ext(ev_ext),
    .ev_contrib(ev_contrib), .ip_fault(ip_fault), .ip_invoker(ip_invoker),
    .ip_newtask(ip_newtask), .fault_valid(fault_valid), .fault_vec(fault_vec),
    .fault_err(fault_err), .fault_ip(fault_ip), .load_en(load_en)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic       pres;
    logic       ts;
    logic       idt;
    logic       ext;
    logic       ctr;
    logic       e_vld;
    logic [7:0] e_vec;
    logic       e_ld;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t TBL [NROWS] = '{
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1},
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd12, 1'b0},
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1},
    '{3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b0},
    '{3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1},
    '{3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0},
    '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8,  1'b0},
    '{3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd12, 1'b0},
    '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0},
    '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0},
    '{3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8,  1'b0},
    '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 1'b0},
    '{3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 1'b0}
  };

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_err(input row_t r, input logic [15:0] s,
                                            input logic [7:0] iv);
    logic idt_eff;
    if (!r.e_vld || r.ctr) return 16'h0000;
    idt_eff = r.idt && (r.kind == 3'd4);
    if (idt_eff) return {5'b00000, iv, 1'b0, 1'b1, r.ext};
    return {s[15:3], s[2], 1'b0, r.ext};
  endfunction

  function automatic logic [31:0] model_ip(input row_t r, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] c);
    if (!r.e_vld) return 32'h0;
    if (r.kind == 3'd4) return b;
    if (r.ts && r.kind <= 3'd2) return c;
    return a;
  endfunction

  function automatic string vec_tag(input row_t r);
    if (r.kind >= 3'd6) return "R11";
    if (!r.e_vld)       return "R2";
    case (r.e_vec)
      8'd8:    return "R6";
      8'd10:   return "R5";
      8'd12:   return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic send(input row_t r, input logic [15:0] s, input logic [7:0] iv,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = r.kind; desc_present = r.pres; in_task_switch = r.ts;
    via_idt = r.idt; ev_ext = r.ext; ev_contrib = r.ctr;
    sel = s; int_vec = iv; ip_fault = a; ip_invoker = b; ip_newtask = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 fault_valid", 32'(fault_valid), 32'd0);
    check_eq("R1 fault_vec", 32'(fault_vec), 32'd0);
    check_eq("R1 fault_err", 32'(fault_err), 32'd0);
    check_eq("R1 fault_ip", fault_ip, 32'd0);
    check_eq("R1 load_en", 32'(load_en), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      logic [15:0] s;
      logic [7:0]  iv;
      logic [31:0] a, b, c;
      r  = TBL[i];
      s  = 16'(i * 16'h0937 + 16'h0004);
      iv = 8'(i * 7 + 32);
      a  = 32'h1000_0000 + 32'(i);
      b  = 32'h2000_0000 + 32'(i);
      c  = 32'h3000_0000 + 32'(i);
      send(r, s, iv, a, b, c);
      check_eq({vec_tag(r), " fault_valid"}, 32'(fault_valid), 32'(r.e_vld));
      check_eq({vec_tag(r), " fault_vec"}, 32'(fault_vec), 32'(r.e_vec));
      check_eq((r.idt && r.kind == 3'd4 && !r.ctr) ? "R8 fault_err" :
               (r.e_vld ? "R7 fault_err" : "R12 fault_err"),
               32'(fault_err), 32'(model_err(r, s, iv)));
      check_eq(r.e_vld ? "R9 fault_ip" : "R12 fault_ip", fault_ip, model_ip(r, a, b, c));
      check_eq("R10 load_en", 32'(load_en), 32'(r.e_ld));
      @(negedge clk);
      check_eq("R2 strobe one cycle only", 32'(fault_valid), 32'd0);
    end

    // R2: descriptor missing but no request strobe
    @(negedge clk);
    req_kind = 3'd0; desc_present = 1'b0; ev_contrib = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check_eq("R2 no request no fault", 32'(fault_valid), 32'd0);
    check_eq("R10 no request no load", 32'(load_en), 32'd0);

    // R2/R10: back-to-back requests, miss then present
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1; desc_present = 1'b0; in_task_switch = 1'b0;
    via_idt = 1'b0; ev_ext = 1'b0; ev_contrib = 1'b0; sel = 16'hFFFF;
    ip_fault = 32'hAAAA_0000;
    @(negedge clk);
    check_eq("R4 back-to-back first vec", 32'(fault_vec), 32'd12);
    check_eq("R7 back-to-back first err", 32'(fault_err), 32'h0000_FFFC);
    desc_present = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R2 back-to-back second no fault", 32'(fault_valid), 32'd0);
    check_eq("R10 back-to-back second load", 32'(load_en), 32'd1);

    // R1: reset while a fault is on the outputs
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd3; desc_present = 1'b0; ip_fault = 32'h5555_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R3 pre-reset fault", 32'(fault_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R1 mid reset fault_valid", 32'(fault_valid), 32'd0);
    check_eq("R1 mid reset fault_ip", fault_ip, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule